// File: doc/BRIEF.md
# NAND Page Hamming Parity Engine

This block sits beside a NAND Flash controller and listens to the command, address and data cycles on the flash bus. A page read or page program opcode arms it. The first address cycle after that opcode starts a fresh page. The block then folds every data byte of the page's main area into single-error-correcting Hamming parity. When the last main-area byte has been seen, it holds the finished codes in a bank of sixteen 32-bit parity registers.

The main area can be covered by a single code, or split into 256-byte or 512-byte sectors with one code each. Software writes the codes into the spare area after a program. After a read, software compares the stored codes with the new ones to locate a flipped bit. The page size, the granularity and the bus width (8 or 16 bits) are taken from the configuration inputs when the page starts.

Top module: `nand_hecc_gen`

## Requirements
- R1: A cycle with `cmd_en` high arms the engine only when `bus[7:0]` is 8'h00 or 8'h80, even while a page is being processed. The next `addr_en` cycle after arming is the start condition: the byte count returns to zero and accumulation restarts. A command with any other opcode changes nothing.
- R2: `page_sel` selects the main-area length as 512 << `page_sel` bytes: 0 gives 512, 1 gives 1024, 2 gives 2048 and 3 gives 4096. Spare bytes follow the main area and are not counted.
- R3: `gran_sel` 0 gives one code over the whole main area, in register 0. `gran_sel` 1 gives one code per 256 bytes and `gran_sel` 2 or 3 gives one code per 512 bytes. In both sector modes, sector n goes to register n, which occupies `parity[32n+31:32n]`.
- R4: With `wide` = 1, each data strobe carries two bytes: `bus[7:0]` is byte index 2k and `bus[15:8]` is byte index 2k+1. With `wide` = 0, each strobe carries one byte on `bus[7:0]`.
- R5: Code layout, where i is the byte index inside the code's range and m is log2 of the range length. Bit k, for k < m, is the XOR of all data bits of the bytes whose i has bit k set. Bit 12+k is the same over the bytes whose i has bit k clear. Bits 24+j (j = 0..2) are the XOR over all bytes of the data bits whose bit position has bit j set. Bits 27+j are the same for bit positions with bit j clear. All other bits are 0.
- R6: `done` is high for exactly one cycle, in the cycle after the edge that accepts the last main-area byte. `valid` rises in that same cycle and stays high until the next start condition. Reset clears both outputs and all registers.
- R7: After the main area ends, further data strobes (spare-area traffic) leave every register unchanged until the next start condition.
- R8: At a start condition, all sixteen registers are cleared. Registers that the selected mode does not use read zero.
- R9: If a single data bit at byte i, bit b of a 512-byte sector is flipped, the XOR of the two codes gives bits [8:0] = i, bits [26:24] = b, and (bits [8:0] XOR bits [20:12]) = 9'h1FF.
- R10: `wide`, `page_sel` and `gran_sel` are sampled at the start condition. Changes to them during a page have no effect on that page.
- R11: Data strobes before the start condition, whether idle or armed, are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_en | input | 1 | Command cycle on the flash bus |
| addr_en | input | 1 | Address cycle on the flash bus |
| data_en | input | 1 | Data word transfer on the flash bus |
| bus | input | 16 | Flash data bus |
| wide | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| page_sel | input | 2 | Main-area size select |
| gran_sel | input | 2 | Code granularity select |
| parity | output | 512 | Sixteen 32-bit parity registers; register n at bits 32n+31:32n |
| done | output | 1 | One-cycle pulse when the main area ends |
| valid | output | 1 | Parity registers hold a finished page |

## Verification
The assertions assume that command, address and data cycles never occur in the same clock cycle. They also assume that a 16-bit page always starts at an even byte index. The bench drives exactly one strobe per cycle and always sends whole words, so it stays within both assumptions. Under these assumptions, `valid` can only fall on an address cycle, and the register bank can only change while `valid` is low.

// File: rtl/nand_hecc_gen.sv
module nand_hecc_gen #(
  parameter int NREG = 16,
  parameter int RW   = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_en,
  input  logic              addr_en,
  input  logic              data_en,
  input  logic [15:0]       bus,
  input  logic              wide,
  input  logic [1:0]        page_sel,
  input  logic [1:0]        gran_sel,
  output logic [NREG*RW-1:0] parity,
  output logic              done,
  output logic              valid
);
  localparam int LB = 12;
  localparam int CB = LB + 1;

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_RUN, S_DONE} st_t;

  st_t           st;
  logic [CB-1:0] cnt;
  logic [RW-1:0] acc;
  logic          wide_q;
  logic [1:0]    psel_q, gsel_q;
  logic [RW-1:0] bank [NREG];

  function automatic logic [RW-1:0] fold(logic [RW-1:0] a, logic [7:0] b,
                                         logic [LB-1:0] idx, logic [LB-1:0] m);
    logic [RW-1:0] r;
    logic p;
    r = a;
    p = ^b;
    for (int k = 0; k < LB; k++)
      if (m[k]) begin
        if (idx[k]) r[k] = r[k] ^ p;
        else        r[LB+k] = r[LB+k] ^ p;
      end
    r[31:24] = r[31:24] ^ b;
    return r;
  endfunction

  function automatic logic [RW-1:0] finish(logic [RW-1:0] a);
    logic [RW-1:0] r;
    logic [7:0] c;
    c = a[31:24];
    r = '0;
    r[23:0] = a[23:0];
    r[24] = ^(c & 8'hAA);
    r[25] = ^(c & 8'hCC);
    r[26] = ^(c & 8'hF0);
    r[27] = ^(c & 8'h55);
    r[28] = ^(c & 8'h33);
    r[29] = ^(c & 8'h0F);
    return r;
  endfunction

  logic [CB-1:0] main_sz, main_m1, cnt_n, cnt_hi;
  logic [LB-1:0] imask;
  logic [3:0]    sec;
  logic [RW-1:0] a1, a2;
  logic          good_cmd, sec_end, main_end;

  assign good_cmd = cmd_en && (bus[7:0] == 8'h00 || bus[7:0] == 8'h80);
  assign main_sz  = CB'(512) << psel_q;
  assign main_m1  = main_sz - CB'(1);
  assign imask    = (gsel_q == 2'd0) ? main_m1[LB-1:0] :
                    (gsel_q == 2'd1) ? LB'(255) : LB'(511);
  assign sec      = (gsel_q == 2'd0) ? 4'd0 :
                    (gsel_q == 2'd1) ? cnt[11:8] : {1'b0, cnt[11:9]};
  assign cnt_n    = cnt + (wide_q ? CB'(2) : CB'(1));
  assign cnt_hi   = cnt + CB'(1);
  assign a1       = fold(acc, bus[7:0], cnt[LB-1:0] & imask, imask);
  assign a2       = wide_q ? fold(a1, bus[15:8], cnt_hi[LB-1:0] & imask, imask) : a1;
  assign sec_end  = (cnt_n[LB-1:0] & imask) == '0;
  assign main_end = cnt_n == main_sz;

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign parity[g*RW +: RW] = bank[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      acc    <= '0;
      done   <= 1'b0;
      valid  <= 1'b0;
      wide_q <= 1'b0;
      psel_q <= '0;
      gsel_q <= '0;
      for (int r = 0; r < NREG; r++) bank[r] <= '0;
    end else begin
      done <= 1'b0;
      if (good_cmd) begin
        st <= S_ARM;
      end else if (st == S_ARM && addr_en) begin
        st     <= S_RUN;
        cnt    <= '0;
        acc    <= '0;
        valid  <= 1'b0;
        wide_q <= wide;
        psel_q <= page_sel;
        gsel_q <= gran_sel;
        for (int r = 0; r < NREG; r++) bank[r] <= '0;
      end else if (st == S_RUN && data_en) begin
        cnt <= cnt_n;
        if (sec_end) begin
          bank[sec] <= finish(a2);
          acc       <= '0;
        end else begin
          acc <= a2;
        end
        if (main_end) begin
          st    <= S_DONE;
          valid <= 1'b1;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

module nand_hecc_gen_chk #(
  parameter int NREG = 16,
  parameter int RW   = 32
)(
  input logic               clk,
  input logic               rst_n,
  input logic               addr_en,
  input logic [NREG*RW-1:0] parity,
  input logic               done,
  input logic               valid
);
  p_done_sets_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> valid);
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_valid_falls_on_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !addr_en) |=> valid);
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !addr_en) |=> $stable(parity));
  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid) |-> parity == '0);
  for (genvar g = 0; g < NREG; g++) begin : g_pad
    p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      parity[g*RW+30 +: 2] == 2'b00);
  end
endmodule

bind nand_hecc_gen nand_hecc_gen_chk #(.NREG(NREG), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_en(addr_en),
  .parity(parity), .done(done), .valid(valid));

// File: tb/nand_hecc_gen_test.sv
`timescale 1ns/1ps
module nand_hecc_gen_test;
  logic clk = 0, rst_n = 0, cmd_en = 0, addr_en = 0, data_en = 0, wide = 0;
  logic [15:0] bus = '0;
  logic [1:0] page_sel = '0, gran_sel = '0;
  wire [511:0] parity;
  wire done, valid;
  int tests = 0, fails = 0;
  bit finished = 0;
  logic [7:0] pg [4096];

  always #2.5 clk = ~clk;

  nand_hecc_gen uut (.clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .addr_en(addr_en),
    .data_en(data_en), .bus(bus), .wide(wide), .page_sel(page_sel),
    .gran_sel(gran_sel), .parity(parity), .done(done), .valid(valid));

  function automatic logic [31:0] model(int base, int len);
    logic [31:0] r = '0;
    int nb = $clog2(len);
    for (int i = 0; i < len; i++)
      for (int b = 0; b < 8; b++)
        if (pg[base+i][b]) begin
          for (int k = 0; k < nb; k++)
            if (i[k]) r[k] = ~r[k]; else r[12+k] = ~r[12+k];
          for (int j = 0; j < 3; j++)
            if (b[j]) r[24+j] = ~r[24+j]; else r[27+j] = ~r[27+j];
        end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(bit c, bit a, bit d, logic [15:0] v);
    @(negedge clk);
    cmd_en = c; addr_en = a; data_en = d; bus = v;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 16'h0);
  endtask

  task automatic start_page(logic [7:0] op);
    cyc(1, 0, 0, {8'h0, op});
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 16'($urandom));
  endtask

  task automatic feed(int from, int n, bit w);
    if (w) for (int i = from; i < from + n; i += 2) cyc(0, 0, 1, {pg[i+1], pg[i]});
    else   for (int i = from; i < from + n; i++)    cyc(0, 0, 1, {8'h0, pg[i]});
  endtask

  task automatic check_bank(int psel, int gran, string req);
    int mlen = 512 << psel;
    int ss = (gran == 0) ? mlen : (gran == 1) ? 256 : 512;
    for (int r = 0; r < 16; r++) begin
      logic [31:0] e = (r < mlen / ss) ? model(r * ss, ss) : 32'h0;
      check(parity[r*32 +: 32] === e, req, parity[r*32 +: 32], e);
    end
  endtask

  task automatic randomize_page();
    for (int i = 0; i < 4096; i++) pg[i] = 8'($urandom);
  endtask

  // R2 R3 R4 R5 R6 R7 R8: full page in one mode with spare traffic after it
  task automatic t_page(int psel, int gran, bit w, logic [7:0] op);
    int mlen = 512 << psel;
    randomize_page();
    page_sel = 2'(psel); gran_sel = 2'(gran); wide = w;
    start_page(op);
    idle();
    check(valid === 1'b0, "R6 valid low after start", 32'(valid), 0);
    feed(0, mlen, w);
    idle();
    check(done === 1'b1 && valid === 1'b1, "R6 done/valid at end", {done, valid}, 32'h3);
    idle();
    check(done === 1'b0 && valid === 1'b1, "R6 done one cycle", {done, valid}, 32'h1);
    for (int i = 0; i < 16; i++) cyc(0, 0, 1, 16'($urandom));
    idle();
    check_bank(psel, gran, "R5 R7 R8 bank");
  endtask

  // R1 R7: foreign opcode and its address/data do not disturb the result
  task automatic t_other_cmd();
    t_page(0, 1, 0, 8'h00);
    cyc(1, 0, 0, 16'h0070);
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 16'h0);
    for (int i = 0; i < 64; i++) cyc(0, 0, 1, 16'($urandom));
    idle();
    check(valid === 1'b1, "R1 other opcode keeps valid", 32'(valid), 1);
    check_bank(0, 1, "R1 other opcode");
  endtask

  // R11 R1: early data ignored, restart mid-page returns to byte 0
  task automatic t_early_and_restart();
    randomize_page();
    page_sel = 2'd1; gran_sel = 2'd2; wide = 0;
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, 16'($urandom));
    cyc(1, 0, 0, 16'h0080);
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, 16'($urandom));
    cyc(0, 1, 0, 16'h0);
    for (int i = 0; i < 100; i++) cyc(0, 0, 1, 16'($urandom));
    cyc(1, 0, 0, 16'h0000);
    cyc(0, 1, 0, 16'h0);
    cyc(0, 1, 0, 16'h0);
    feed(0, 1024, 0);
    idle();
    check(done === 1'b1, "R1 restart ends at 1024", 32'(done), 1);
    check_bank(1, 2, "R11 R1 early data and restart");
  endtask

  // R10: configuration changes after the start are ignored
  task automatic t_cfg_latch();
    randomize_page();
    page_sel = 2'd0; gran_sel = 2'd2; wide = 0;
    start_page(8'h00);
    page_sel = 2'd3; gran_sel = 2'd0; wide = 1;
    feed(0, 512, 0);
    idle();
    check(done === 1'b1, "R10 ends at latched size", 32'(done), 1);
    check_bank(0, 2, "R10 latched config");
  endtask

  // R9: single flipped bit is located by the syndrome
  task automatic t_syndrome();
    logic [31:0] c0, s;
    randomize_page();
    page_sel = 2'd0; gran_sel = 2'd2; wide = 1;
    start_page(8'h00); feed(0, 512, 1); idle();
    c0 = parity[31:0];
    pg[300][5] = ~pg[300][5];
    start_page(8'h00); feed(0, 512, 1); idle();
    s = c0 ^ parity[31:0];
    check(s[8:0] == 9'd300, "R9 byte index", 32'(s[8:0]), 300);
    check(s[26:24] == 3'd5, "R9 bit index", 32'(s[26:24]), 5);
    check((s[8:0] ^ s[20:12]) == 9'h1FF, "R9 complement", 32'(s[8:0] ^ s[20:12]), 32'h1FF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle();
    check(valid === 1'b0 && done === 1'b0, "R6 reset outputs", {done, valid}, 0);
    check(parity === '0, "R6 reset bank", parity[31:0], 0);
    for (int p = 0; p < 4; p++)
      for (int g = 0; g < 3; g++)
        for (int w = 0; w < 2; w++)
          t_page(p, g, w[0], (w == 0) ? 8'h00 : 8'h80);
    t_page(0, 3, 0, 8'h00);
    t_other_cmd();
    t_early_and_restart();
    t_cfg_latch();
    t_syndrome();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule